// File: doc/BRIEF.md
# ADC Output Mute and Overload Flag

This block sits between the decimation stage of a stereo ADC and its serial output. After reset, or after a restart pulse that marks power-down recovery or clock start, it replaces the output samples with zero until the decimation and DC-removal filters have settled. The length of that quiet interval is counted in sample strobes. It is 1024 samples with the DC-removal filter off and 12288 samples with it on.

Once the output is live, every left and right sample is compared with a threshold near full scale. A sample on either channel above the threshold raises an overload flag. The flag then stays high for a minimum number of sample periods, and every further over-threshold sample starts that hold time again.

Top module: `adc_out_guard`

## Requirements
- R1: With rst_n low, and in the cycle after a restart pulse, out_valid, out_l, out_r and ovl are all 0. A restart takes priority over a strobe in the same cycle.
- R2: With dc_en low, the first 1024 strobes after reset or restart produce out_l = out_r = 0. From the 1025th strobe on, the input samples pass unchanged.
- R3: With dc_en high during the mute interval, the first 12288 strobes produce zero output, and the 12289th strobe passes its data. Once the interval has ended, a change of dc_en does not mute the output again.
- R4: Each strobe updates out_l and out_r and sets out_valid at the next rising clock edge. out_valid is low in the cycle after a clock with no strobe.
- R5: Samples are 20-bit two's complement. The magnitude of a sample is its absolute value. If the magnitude of either channel exceeds 458752 (7/8 of 2^19), ovl is high in the same cycle as the output of that sample. A magnitude of exactly 458752 does not set ovl.
- R6: The most negative code, -524288, is treated as magnitude 524287 and sets ovl. The code -458752 does not set ovl.
- R7: After the last over-threshold sample, ovl stays high through the next 511 strobes that are not over the threshold. It goes low with the 512th such strobe.
- R8: An over-threshold sample that arrives while ovl is high starts the 512-strobe hold again.
- R9: ovl is never high during the mute interval. Over-threshold samples during the mute do not set ovl. A restart clears ovl.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | One-cycle pulse that starts the mute interval again |
| dc_en | input | 1 | DC-removal filter enabled; selects the long mute interval |
| smp_valid | input | 1 | Sample strobe from the decimator |
| smp_l | input | 20 | Left sample, two's complement |
| smp_r | input | 20 | Right sample, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_l | output | 20 | Gated left sample |
| out_r | output | 20 | Gated right sample |
| ovl | output | 1 | Overload flag |

## Verification
The hardest states to reach are the boundary strobes at the end of each mute interval, and above all the 12288th and 12289th strobes with the DC filter on. The bench streams full-scale samples through the entire interval. At the last muted strobe it checks that the output is still zero and that the flag is still low, and it checks that the next strobe passes its data. The hold and retrigger edges are reached the same way: the bench counts exactly 511 and 512 quiet strobes after a trigger, and also retriggers partway through a hold.

// File: rtl/adc_out_guard.sv
module adc_out_guard #(
  parameter int DW         = 20,
  parameter int MUTE_PLAIN = 1024,
  parameter int MUTE_DC    = 12288,
  parameter int HOLD       = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          dc_en,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_l,
  input  logic [DW-1:0] smp_r,
  output logic          out_valid,
  output logic [DW-1:0] out_l,
  output logic [DW-1:0] out_r,
  output logic          ovl
);
  localparam int MW = $clog2(MUTE_DC + 1);
  localparam int HW = $clog2(HOLD + 1);
  localparam logic [DW-1:0] MAXPOS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MINNEG = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] THRESH = DW'((64'd7 << (DW-1)) / 64'd8);

  logic [MW-1:0] mute_cnt;
  logic          mute_done;
  logic [HW-1:0] hold_cnt;

  wire muted = !mute_done;
  wire [MW-1:0] mute_last = dc_en ? MW'(MUTE_DC - 1) : MW'(MUTE_PLAIN - 1);

  function automatic logic [DW-1:0] mag(input logic [DW-1:0] v);
    if (!v[DW-1])       return v;
    else if (v == MINNEG) return MAXPOS;
    else                return -v;
  endfunction

  wire over = (mag(smp_l) > THRESH) || (mag(smp_r) > THRESH);

  assign ovl = (hold_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute_cnt  <= '0;
      mute_done <= 1'b0;
      hold_cnt  <= '0;
      out_valid <= 1'b0;
      out_l     <= '0;
      out_r     <= '0;
    end else if (restart) begin
      mute_cnt  <= '0;
      mute_done <= 1'b0;
      hold_cnt  <= '0;
      out_valid <= 1'b0;
      out_l     <= '0;
      out_r     <= '0;
    end else begin
      out_valid <= smp_valid;
      if (smp_valid) begin
        if (muted) begin
          out_l <= '0;
          out_r <= '0;
          if (mute_cnt >= mute_last) mute_done <= 1'b1;
          else                       mute_cnt  <= mute_cnt + 1'b1;
        end else begin
          out_l <= smp_l;
          out_r <= smp_r;
          if (over)                  hold_cnt <= HW'(HOLD);
          else if (hold_cnt != '0)   hold_cnt <= hold_cnt - 1'b1;
        end
      end
    end
  end

  AST_MUTED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && muted && !restart) |=> (out_l == '0 && out_r == '0)); // R2
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !restart) |=> out_valid); // R4
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!ovl && !out_valid)); // R1
  AST_NO_OVL_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    muted |-> !ovl); // R9
  AST_OVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !muted && !restart && over) |=> (ovl && hold_cnt == HW'(HOLD))); // R8
  AST_HOLD_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ovl) && !$past(restart)) |-> ($past(hold_cnt) == HW'(1) && $past(smp_valid))); // R7
endmodule

// File: tb/adc_out_guard_bench.sv
`timescale 1ns/1ps
module adc_out_guard_bench;
  logic clk = 0, rst_n = 0, restart = 0, dc_en = 0, smp_valid = 0;
  logic [19:0] smp_l = '0, smp_r = '0;
  logic out_valid, ovl;
  logic [19:0] out_l, out_r;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  adc_out_guard u_adc_out_guard (
    .clk(clk), .rst_n(rst_n), .restart(restart), .dc_en(dc_en),
    .smp_valid(smp_valid), .smp_l(smp_l), .smp_r(smp_r),
    .out_valid(out_valid), .out_l(out_l), .out_r(out_r), .ovl(ovl));

  // {left, right, expected ovl}
  localparam logic [40:0] VEC [8] = '{
    {20'h70000, 20'h00000, 1'b0},
    {20'h70001, 20'h00000, 1'b1},
    {20'h00000, 20'h8FFFF, 1'b1},
    {20'h80000, 20'h00000, 1'b1},
    {20'h90000, 20'h70000, 1'b0},
    {20'h7FFFF, 20'h7FFFF, 1'b1},
    {20'h03039, 20'hFCFC7, 1'b0},
    {20'h00000, 20'h80000, 1'b1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic snd(input logic [19:0] l, input logic [19:0] r);
    @(negedge clk);
    smp_l = l; smp_r = r; smp_valid = 1;
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic rst_pulse();
    @(negedge clk);
    restart = 1;
    @(negedge clk);
    restart = 0;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) snd(20'h00100, 20'hFFF00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", out_valid, 0);
    chk("R1 reset ovl", ovl, 0);
    chk("R1 reset data", {out_l, out_r}, 0);
    rst_n = 1;

    for (int v = 0; v < 8; v++) begin
      rst_pulse();
      chk("R1 restart clears ovl", ovl, 0);
      for (int i = 0; i < 1024; i++) snd(20'h7FFFF, 20'h80000);
      chk("R2 last muted sample zero", {out_l, out_r}, 0);
      chk("R9 no ovl in mute", ovl, 0);
      snd(VEC[v][40:21], VEC[v][20:1]);
      chk("R2 data passes", {out_l, out_r}, {VEC[v][40:21], VEC[v][20:1]});
      chk("R5 R6 threshold", ovl, VEC[v][0]);
    end

    // R4 valid timing
    @(negedge clk); smp_valid = 1; smp_l = 20'h00055; smp_r = 20'h000AA;
    @(negedge clk); smp_valid = 0;
    chk("R4 out_valid after strobe", out_valid, 1);
    chk("R4 data after strobe", {out_l, out_r}, {20'h00055, 20'h000AA});
    @(negedge clk);
    chk("R4 out_valid low without strobe", out_valid, 0);

    // R7 hold length
    snd(20'h7FFFF, 20'h0);
    chk("R7 trigger", ovl, 1);
    quiet(511);
    chk("R7 held after 511 quiet", ovl, 1);
    quiet(1);
    chk("R7 drops after 512 quiet", ovl, 0);

    // R8 retrigger
    snd(20'h0, 20'h80000);
    quiet(300);
    snd(20'h75000, 20'h0);
    quiet(511);
    chk("R8 retrigger extends hold", ovl, 1);
    quiet(1);
    chk("R8 drop after retriggered hold", ovl, 0);

    // R9 restart clears ovl
    snd(20'h7FFFF, 20'h0);
    rst_pulse();
    chk("R9 restart clears ovl", ovl, 0);

    // R1 restart beats strobe
    @(negedge clk); restart = 1; smp_valid = 1; smp_l = 20'h12345;
    @(negedge clk); restart = 0; smp_valid = 0;
    chk("R1 restart priority", out_valid, 0);

    // R3 DC mute
    dc_en = 1;
    rst_pulse();
    for (int i = 0; i < 12287; i++) snd(20'h7FFFF, 20'h7FFFF);
    snd(20'h7FFFF, 20'h7FFFF);
    chk("R3 12288th still muted", {out_l, out_r}, 0);
    chk("R9 no ovl in long mute", ovl, 0);
    snd(20'h01234, 20'h04321);
    chk("R3 12289th passes", {out_l, out_r}, {20'h01234, 20'h04321});
    dc_en = 0;
    snd(20'h00777, 20'h00888);
    chk("R3 no re-mute on dc_en change", {out_l, out_r}, {20'h00777, 20'h00888});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule